// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address that a synchronous burst memory uses on each clock cycle. When the qualified address strobe is sampled, the full external address is captured and becomes the current address on the following cycle. The upper address field then stays frozen. Only the low burst field moves, and it does so on cycles where the active-low advance input is sampled low. A cycle with advance high holds the current address.

A static order-select pin picks how the low field steps. With the pin low the field counts upward modulo four from the captured value and wraps. With the pin high the field is the captured low bits XORed with a beat counter, which gives the interleaved order. The order pin is not registered: the output decodes it together with the stored beat count. A new strobe always restarts the burst at beat zero, even when advance is asserted in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and after it is released with no strobe, `addr_out` is all zeros.
- R2: On the cycle after `load` is sampled high, `addr_out` equals the `addr_in` value sampled with it, in either order mode.
- R3: When `load` and advance (`adv_n` low) are sampled together, the load wins and the output equals the new external address with the burst at its first beat.
- R4: While `load` is low, the upper field `addr_out[ADDR_W-1:2]` keeps the value loaded last, whatever `addr_in` carries.
- R5: With `mode` = 0 (linear), each advance adds one modulo four to the low two bits, for example 10, 11, 00, 01.
- R6: With `mode` = 1 (interleaved), the low two bits after k advances equal the loaded low bits XOR (k mod 4), for example a start of 01 gives 01, 00, 11, 10.
- R7: A cycle with `adv_n` sampled high and `load` low leaves `addr_out` unchanged.
- R8: After four advances the low field is back at the loaded start value, and stepping continues around the same group of four.
- R9: `mode` is not registered: a change of `mode` alters `addr_out` with no clock edge, and the output then follows the new order using the number of advances made since the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Qualified address strobe; captures `addr_in` and restarts the burst |
| adv_n | input | 1 | Advance, active low; steps the burst field one beat |
| mode | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current word address |

## Verification
On every cycle the assertions check these behaviours: the load capture, the frozen upper field, the hold on an idle cycle, the modulo-four increment in linear order, and the low-bit toggle that every interleaved step shows. The exact interleaved sequence cannot be seen from the ports in one cycle, because it depends on the loaded start bits. The same holds for the wrap back to the start after four beats and for the combinational effect of a change of the order pin. These are shown only by the bench's scenarios. The bench sweeps every start offset in both orders, with a hold in mid-burst, a reload during a burst and an order change.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // Order encoding on the static select pin
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   // Linear step: offset added modulo the burst length
   function automatic logic [7:0] lin_offset(input logic [7:0] start, input logic [7:0] beat,
                                             input int unsigned bits);
      logic [7:0] sum;
      logic [7:0] msk;
      sum = start + beat;
      msk = 8'((1 << bits) - 1);
      return sum & msk;
   endfunction

   // Interleaved step: start bits XOR beat count
   function automatic logic [7:0] ilv_offset(input logic [7:0] start, input logic [7:0] beat);
      return start ^ beat;
   endfunction
endpackage

// File: rtl/bseq_addr_hold.sv
module bseq_addr_hold #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned BURST_BITS = 2,
   localparam int unsigned UP_W      = ADDR_W - BURST_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [ADDR_W-1:0]     addr_in,
   output logic [UP_W-1:0]       upper_q,
   output logic [BURST_BITS-1:0] start_q
);
   // Captured address, split into the frozen field and the burst start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
      end else if (load) begin
         upper_q <= addr_in[ADDR_W-1:BURST_BITS];
         start_q <= addr_in[BURST_BITS-1:0];
      end
   end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int unsigned BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  adv_n,
   output logic [BURST_BITS-1:0] beat_q
);
   // Beats since the last load; free-running wrap gives the circular burst
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      beat_q <= '0;
      else if (load)   beat_q <= '0;
      else if (!adv_n) beat_q <= beat_q + 1'b1;
   end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
   parameter int unsigned BURST_BITS     = 2,
   parameter bit          HAS_INTERLEAVE = 1'b1
) (
   input  logic                  mode,
   input  logic [BURST_BITS-1:0] start_q,
   input  logic [BURST_BITS-1:0] beat_q,
   output logic [BURST_BITS-1:0] low_out
);
   import burst_seq_pkg::*;

   logic [BURST_BITS-1:0] lin_low;
   assign lin_low = start_q + beat_q;

   generate
      if (HAS_INTERLEAVE) begin : g_both
         logic [BURST_BITS-1:0] ilv_low;
         assign ilv_low = start_q ^ beat_q;
         always_comb begin
            unique case (order_e'(mode))
               ORD_INTERLEAVE: low_out = ilv_low;
               default:        low_out = lin_low;
            endcase
         end
      end else begin : g_lin_only
         logic unused_mode;
         assign unused_mode = mode;
         assign low_out     = lin_low;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int unsigned ADDR_W         = 15,
   parameter int unsigned BURST_BITS     = 2,
   parameter bit          HAS_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv_n,
   input  logic              mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int unsigned UP_W = ADDR_W - BURST_BITS;

   generate
      if (BURST_BITS < 1 || BURST_BITS > 8) begin : g_bad_bits
         $error("burst_addr_seq: BURST_BITS must be 1..8");
      end
      if (ADDR_W <= BURST_BITS) begin : g_bad_width
         $error("burst_addr_seq: ADDR_W must exceed BURST_BITS");
      end
   endgenerate

   logic [UP_W-1:0]       upper_q;
   logic [BURST_BITS-1:0] start_q;
   logic [BURST_BITS-1:0] beat_q;
   logic [BURST_BITS-1:0] low_out;

   bseq_addr_hold #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr_in (addr_in),
      .upper_q (upper_q),
      .start_q (start_q)
   );

   bseq_beat_ctr #(.BURST_BITS(BURST_BITS)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .adv_n  (adv_n),
      .beat_q (beat_q)
   );

   bseq_order_map #(.BURST_BITS(BURST_BITS), .HAS_INTERLEAVE(HAS_INTERLEAVE)) u_map (
      .mode    (mode),
      .start_q (start_q),
      .beat_q  (beat_q),
      .low_out (low_out)
   );

   assign addr_out = {upper_q, low_out};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned BURST_BITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic              adv_n,
   input logic              mode,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out
);
   logic [BURST_BITS-1:0] lo;
   assign lo = addr_out[BURST_BITS-1:0];

   always_comb begin
      if (!rst_n) p_reset_zero_r1: assert (addr_out == '0);
   end

   // R2 and R3: a strobe captures the external address whatever advance does
   p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_out == $past(addr_in));

   // R4
   p_upper_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));

   // R7
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=> (mode != $past(mode)) || $stable(addr_out));

   // R5
   p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && !mode) |=> mode || (lo == BURST_BITS'($past(lo) + 1'b1)));

   // R6
   p_ilv_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && mode) |=> !mode || (lo[0] != $past(lo[0])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load     (load),
   .adv_n    (adv_n),
   .mode     (mode),
   .addr_in  (addr_in),
   .addr_out (addr_out)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load = 1'b0;
   logic          adv_n = 1'b1;
   logic          mode = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // Independent model state
   logic [AW-3:0] m_up = '0;
   logic [1:0]    m_start = '0;
   int            m_beats = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2), .HAS_INTERLEAVE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .load(load), .adv_n(adv_n), .mode(mode),
      .addr_in(addr_in), .addr_out(addr_out)
   );

   function automatic logic [AW-1:0] expect_addr();
      logic [1:0] k;
      logic [1:0] low;
      k = 2'(m_beats % 4);
      if (mode) low = m_start ^ k;
      else      low = 2'((int'(m_start) + m_beats) % 4);
      return {m_up, low};
   endfunction

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: addr_out=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock: update the model from the inputs present at the edge
   task automatic tick();
      if (rst_n) begin
         if (load) begin
            m_up = addr_in[AW-1:2];
            m_start = addr_in[1:0];
            m_beats = 0;
         end else if (!adv_n) begin
            m_beats++;
         end
      end
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: addr_out=%h expected=finish", addr_out);
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      addr_in = 8'hA5;
      tick(); tick();
      check("R1 reset", addr_out, '0);
      rst_n = 1'b1;
      tick();
      check("R1 after release", addr_out, '0);

      // Sweep both orders and every start offset
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            mode = m[0];
            load = 1'b1;
            adv_n = 1'b1;
            addr_in = {6'((m * 4 + s) * 7 + 5), 2'(s)};
            tick();
            load = 1'b0;
            check("R2 load", addr_out, addr_in);
            addr_in = ~addr_in;
            adv_n = 1'b0;
            for (int k = 1; k <= 6; k++) begin
               if (k == 3) begin
                  adv_n = 1'b1;
                  tick();
                  check("R7 hold", addr_out, expect_addr());
                  adv_n = 1'b0;
               end
               tick();
               check(m ? "R6 interleaved" : "R5 linear", addr_out, expect_addr());
               check("R4 upper", {addr_out[AW-1:2], 2'b00}, {m_up, 2'b00});
               if (k == 4) check("R8 wrap", addr_out, {m_up, 2'(s)});
            end
         end
      end

      // Reload during a burst with advance asserted
      mode = 1'b0;
      load = 1'b1; adv_n = 1'b1; addr_in = 8'h31;
      tick();
      load = 1'b0; adv_n = 1'b0;
      tick(); tick();
      check("R5 before reload", addr_out, 8'h33);
      load = 1'b1; adv_n = 1'b0; addr_in = 8'hC2;
      tick();
      load = 1'b0; adv_n = 1'b1;
      check("R3 load priority", addr_out, 8'hC2);
      adv_n = 1'b0;
      tick();
      check("R3 restart beat", addr_out, 8'hC3);

      // Order pin change mid-burst, no clock edge
      load = 1'b1; adv_n = 1'b1; addr_in = 8'h55;
      tick();
      load = 1'b0; adv_n = 1'b0;
      tick();
      adv_n = 1'b1;
      check("R9 linear", addr_out, 8'h56);
      mode = 1'b1;
      #1;
      check("R9 switch", addr_out, 8'h54);
      adv_n = 1'b0;
      tick();
      check("R9 continue", addr_out, expect_addr());
      check("R9 value", addr_out, 8'h57);
      adv_n = 1'b1;
      mode = 1'b0;
      #1;
      check("R9 back linear", addr_out, 8'h57);
      tick();

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule